// File: doc/BRIEF.md
# Byte-Wide Associative Lookup Table

This block is a small content-addressable store of byte-wide keys. The number of entries is set by a parameter, with 16 as the default. A client loads an entry by presenting a byte and a slot number. The load completes only if the write strobe stays high for two back-to-back clock cycles. A lookup presents a byte with the search strobe raised. A few cycles later the block reports whether any loaded slot holds that byte and, if so, which slot, as a binary number. When several slots hold the same byte, the lowest-numbered one wins.

Every input passes through one register stage, including the active-low match clear. The comparison result is captured in a second stage and driven out through a third. While the search strobe is low, the reported slot and hit flag keep their last values, whatever happens on the key lines. Pulling the match clear low during a lookup forces the reported slot to zero. The hit flag is still reported. A build-time switch adds an address-valid output. An asynchronous active-high reset empties the table and clears all results.

Top module: `byte_cam`

## Requirements
- R1: While `rst` is high, `hit`, `hit_addr` and `addr_ok` are zero, and the asynchronous reset marks every slot empty, so a lookup made after reset misses until that slot is loaded again.
- R2: A slot is loaded with the byte on `key_in` at slot number `wr_addr` only when `wr_en` is high at two consecutive rising edges, with `key_in` and `wr_addr` held over both cycles; a one-cycle pulse of `wr_en` loads nothing.
- R3: While `srch_en` is low, `hit` and `hit_addr` keep their last values, whatever `key_in` and `clr_n` do.
- R4: A lookup made with `clr_n` low reports `hit_addr` equal to zero while `hit` still reflects the comparison.
- R5: `hit` is 1 exactly when a loaded slot holds the searched byte; a miss reports `hit_addr` equal to zero.
- R6: When several loaded slots hold the searched byte, `hit_addr` is the lowest of their slot numbers.
- R7: A lookup whose `srch_en` and `key_in` are sampled at rising edge N appears on the outputs just after rising edge N+2.
- R8: With `HAS_VALID` set, `addr_ok` equals `hit` AND the sampled `clr_n` of the same lookup; with it cleared, `addr_ok` is always 0.
- R9: Loading a slot again replaces its byte, so the old byte no longer matches that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| key_in | input | KW | Byte to load or to search for |
| wr_addr | input | AW | Slot number for a load |
| wr_en | input | 1 | Load strobe, held two cycles |
| srch_en | input | 1 | Lookup strobe |
| clr_n | input | 1 | Active-low clear of the reported slot during a lookup |
| hit_addr | output | AW | Lowest matching slot number |
| hit | output | 1 | A loaded slot matched |
| addr_ok | output | 1 | `hit_addr` is meaningful (optional) |

## Verification
A lookup and the completing edge of a load can land on the same slot in the same cycle, because both use the one registered key. The bench provokes this by holding `srch_en` high through both cycles of a load that rewrites a slot already holding another byte. The lookup therefore races the commit. Each of the two results is accepted if it equals either the table before the load or the table after it. Later lookups must then see only the new contents.

// File: rtl/byte_cam.sv
module byte_cam #(
  parameter int DEPTH     = 16,
  parameter int KW        = 8,
  parameter bit HAS_VALID = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [KW-1:0] key_in,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_en,
  input  logic          srch_en,
  input  logic          clr_n,
  output logic [AW-1:0] hit_addr,
  output logic          hit,
  output logic          addr_ok
);

  logic [KW-1:0]    key_q;
  logic [AW-1:0]    addr_q;
  logic             srch_q, clr_q, wr_d;
  logic [KW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld, eq;
  logic [AW-1:0]    enc, m_addr;
  logic             any, m_hit, m_ok;
  logic             commit, in_range;

  assign commit   = wr_en & wr_d;
  assign in_range = {1'b0, addr_q} < (AW+1)'(DEPTH);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      key_q  <= '0;
      addr_q <= '0;
      srch_q <= 1'b0;
      clr_q  <= 1'b1;
      wr_d   <= 1'b0;
    end else begin
      key_q  <= key_in;
      addr_q <= wr_addr;
      srch_q <= srch_en;
      clr_q  <= clr_n;
      wr_d   <= wr_en & ~wr_d;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      vld <= '0;
    else if (commit && in_range)
      vld[addr_q] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (commit && in_range)
      mem[addr_q] <= key_q;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = vld[g] && (mem[g] == key_q);
  end

  always_comb begin
    enc = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (eq[i]) enc = AW'(i);
  end

  assign any = |eq;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      m_addr <= '0;
      m_hit  <= 1'b0;
      m_ok   <= 1'b0;
    end else if (srch_q) begin
      m_addr <= clr_q ? enc : '0;
      m_hit  <= any;
      m_ok   <= any & clr_q;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hit_addr <= '0;
      hit      <= 1'b0;
    end else begin
      hit_addr <= m_addr;
      hit      <= m_hit;
    end
  end

  if (HAS_VALID) begin : g_ok
    always_ff @(posedge clk or posedge rst) begin
      if (rst) addr_ok <= 1'b0;
      else     addr_ok <= m_ok;
    end
  end else begin : g_no_ok
    assign addr_ok = 1'b0;
  end

endmodule

module byte_cam_chk #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             srch_q,
  input logic             clr_q,
  input logic             any,
  input logic [DEPTH-1:0] vld,
  input logic [AW-1:0]    m_addr,
  input logic             m_hit,
  input logic             hit,
  input logic             addr_ok
);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !srch_q |=> $stable(m_addr) && $stable(m_hit)); // R3

  AST_CLR_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    srch_q && !clr_q |=> m_addr == '0); // R4

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    srch_q && !any |=> !m_hit && m_addr == '0); // R5

  AST_OK_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    addr_ok |-> hit); // R8

  AST_WRITE_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    !$stable(vld) |-> $past(wr_en) && $past(wr_en, 2)); // R2

endmodule

bind byte_cam byte_cam_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .srch_q(srch_q), .clr_q(clr_q),
  .any(any), .vld(vld), .m_addr(m_addr), .m_hit(m_hit), .hit(hit),
  .addr_ok(addr_ok)
);

// File: tb/tb_byte_cam.sv
module tb_byte_cam;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] key_in = '0;
  logic [AW-1:0] wr_addr = '0;
  logic wr_en = 1'b0, srch_en = 1'b0, clr_n = 1'b1;
  logic [AW-1:0] hit_addr;
  logic hit, addr_ok;

  byte_cam #(.DEPTH(DEPTH), .KW(8), .HAS_VALID(1'b1)) dut (
    .clk(clk), .rst(rst), .key_in(key_in), .wr_addr(wr_addr), .wr_en(wr_en),
    .srch_en(srch_en), .clr_n(clr_n), .hit_addr(hit_addr), .hit(hit),
    .addr_ok(addr_ok)
  );

  always #10 clk = ~clk;

  typedef struct {
    int            due;
    logic          h, o, ah, ao;
    logic [AW-1:0] a, aa;
    string         tag;
  } item_t;

  item_t sb[$];
  item_t it, last;
  int cyc = 0, checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] mm [DEPTH];
  logic [DEPTH-1:0] mv = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      checks++;
      if (!((hit === it.h && hit_addr === it.a && addr_ok === it.o) ||
            (hit === it.ah && hit_addr === it.aa && addr_ok === it.ao))) begin
        failures++;
        $display("FAIL %s cyc=%0d: got hit=%0b addr=%0d ok=%0b, expected hit=%0b addr=%0d ok=%0b",
                 it.tag, cyc, hit, hit_addr, addr_ok, it.h, it.a, it.o);
      end
    end
  end

  task automatic lookup(input logic [7:0] k, output logic h, output logic [AW-1:0] a);
    h = 1'b0; a = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (mv[i] && mm[i] == k) begin h = 1'b1; a = AW'(i); end
  endtask

  task automatic direct(input string tag, input logic eh, input logic [AW-1:0] ea, input logic eo);
    checks++;
    if (hit !== eh || hit_addr !== ea || addr_ok !== eo) begin
      failures++;
      $display("FAIL %s: got hit=%0b addr=%0d ok=%0b, expected hit=%0b addr=%0d ok=%0b",
               tag, hit, hit_addr, addr_ok, eh, ea, eo);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] k);
    wr_en = 1'b1; key_in = k; wr_addr = a;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    mm[a] = k; mv[a] = 1'b1;
  endtask

  task automatic do_search(input logic [7:0] k, input logic c, input string tag);
    item_t x;
    logic h;
    logic [AW-1:0] a;
    lookup(k, h, a);
    key_in = k; clr_n = c; srch_en = 1'b1;
    x.due = cyc + 3; x.h = h; x.a = c ? a : '0; x.o = h & c;
    x.ah = x.h; x.aa = x.a; x.ao = x.o; x.tag = tag;
    sb.push_back(x);
    last = x;
    @(negedge clk);
    srch_en = 1'b0; clr_n = 1'b1;
  endtask

  task automatic hold_probe();
    item_t x;
    repeat (5) begin
      key_in = 8'($urandom); clr_n = 1'($urandom); wr_addr = AW'($urandom);
      @(negedge clk);
    end
    clr_n = 1'b1;
    x = last; x.due = cyc + 1; x.tag = "R3 hold while search disabled";
    sb.push_back(x);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_racing_search(input logic [AW-1:0] a, input logic [7:0] k);
    item_t x;
    logic oh, nh;
    logic [AW-1:0] oa, na;
    logic [7:0] sm;
    logic sv;
    lookup(k, oh, oa);
    sm = mm[a]; sv = mv[a];
    mm[a] = k; mv[a] = 1'b1;
    lookup(k, nh, na);
    mm[a] = sm; mv[a] = sv;
    x.h = oh; x.a = oa; x.o = oh; x.ah = nh; x.aa = na; x.ao = nh;
    x.tag = "R9 search racing write commit";
    wr_en = 1'b1; srch_en = 1'b1; clr_n = 1'b1; key_in = k; wr_addr = a;
    x.due = cyc + 3; sb.push_back(x);
    @(negedge clk);
    x.due = cyc + 3; sb.push_back(x);
    @(negedge clk);
    wr_en = 1'b0; srch_en = 1'b0;
    mm[a] = k; mv[a] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] keys [6];
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    direct("R1 outputs during reset", 1'b0, '0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    direct("R1 outputs after reset", 1'b0, '0, 1'b0);
    do_search(8'h00, 1'b1, "R1 empty table misses");
    repeat (4) @(negedge clk);

    keys = '{8'h11, 8'h22, 8'hA5, 8'h3C, 8'hF0, 8'h7E};
    for (int i = 0; i < 6; i++) do_write(AW'(2 * i + 1), keys[i]);
    for (int i = 0; i < 6; i++) do_search(keys[i], 1'b1, "R7 lookup of loaded byte");
    do_search(8'h99, 1'b1, "R5 miss gives zero address");
    repeat (4) @(negedge clk);

    wr_en = 1'b1; key_in = 8'h5D; wr_addr = 4'd4;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    do_search(8'h5D, 1'b1, "R2 single-cycle strobe loads nothing");
    repeat (4) @(negedge clk);

    do_write(4'd12, 8'hA5);
    do_write(4'd0, 8'h3C);
    do_search(8'hA5, 1'b1, "R6 lowest duplicate slot");
    do_search(8'h3C, 1'b1, "R6 duplicate at slot zero");
    do_search(8'h7E, 1'b0, "R4 clear forces zero address");
    do_search(8'h7E, 1'b1, "R8 address valid with clear high");
    do_search(8'h42, 1'b0, "R8 miss under clear");
    repeat (4) @(negedge clk);
    hold_probe();

    do_write(4'd3, 8'h66);
    do_search(8'h22, 1'b1, "R9 old byte gone after reload");
    do_search(8'h66, 1'b1, "R9 new byte found");
    repeat (4) @(negedge clk);
    hold_probe();

    for (int n = 0; n < 40; n++) begin
      logic [7:0] k;
      if (n % 2 == 0) k = mm[$urandom_range(0, DEPTH - 1)];
      else k = 8'($urandom);
      do_search(k, (n % 7) != 3, "R5 random lookup");
    end
    repeat (4) @(negedge clk);
    hold_probe();

    do_write(4'd14, 8'hC3);
    write_racing_search(4'd14, 8'h5A);
    do_search(8'hC3, 1'b1, "R9 after racing reload old byte");
    do_search(8'h5A, 1'b1, "R9 after racing reload new byte");
    repeat (4) @(negedge clk);

    #5 rst = 1'b1;
    #1 direct("R1 asynchronous clear", 1'b0, '0, 1'b0);
    mv = '0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    do_search(8'h5A, 1'b1, "R1 table empty after reset");
    repeat (6) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule